// File: doc/BRIEF.md
# Variable-Rate Looping Sample Address Generator

This block produces the byte addresses of a single sample stream stored in an external memory. The host programs a start page and a stop page, each a 16-bit count of 256-byte pages, a 16-bit rate word and a few control bits, all through a byte-wide register port. On every pulse of the base-rate `tick` input, the rate word is added to a 16-bit phase accumulator. Each carry out of that accumulator moves the sample address forward by one byte and raises a one-cycle fetch strobe together with the new address. The sample rate is therefore the tick rate times rate/65536. A base tick of about 55.5 kHz, for example, gives a rate that scales linearly with the rate word.

When a carry arrives while the address sits on the last byte of the stop page, the end of the sample has been passed, and the block pulses `end_pulse`. With looping enabled it then jumps back to the first byte of the start page and fetches there. Without looping it halts. The left/right routing bits and the volume byte are held and presented on outputs for the mixing stage downstream. Decoding and gain are not part of this block.

Top module: `vrsp_player`

## Requirements
- R1: While reset is held and right after it, `fetch_stb`, `end_pulse`, `active`, `out_left`, `out_right` and `volume` are all 0.
- R2: Writing address 0x11 sets `out_left` from data bit 7 and `out_right` from data bit 6, visible the cycle after the write.
- R3: Writing address 0x1B presents the data byte on `volume` the cycle after the write.
- R4: A write to the control address 0x10 with bit 7 (start) set and bit 0 (reset) clear raises `active`, clears the phase accumulator and gives a `fetch_stb` in the next cycle.
- R5: The start page is written as low/high bytes at 0x12/0x13 and the stop page at 0x14/0x15. `fetch_addr` is 24 bits wide and equals page*256 + byte offset. A start fetches at offset 0x00 of the start page.
- R6: The rate word is written as low/high bytes at 0x19/0x1A. Each `tick` while active adds it to a 16-bit accumulator. Each carry advances the address by one and strobes it in the next cycle, so N ticks after a start yield floor(N*rate/65536) fetches.
- R7: In a cycle where neither `tick` nor a write is present, no fetch and no end pulse follow.
- R8: A carry taken while the address equals byte 0xFF of the stop page gives a one-cycle `end_pulse`.
- R9: If the control write had bit 4 (repeat) set, passing the end reloads the start page at offset 0x00, strobes that fetch together with `end_pulse`, and stays active.
- R10: If repeat is clear, passing the end drops `active` with no fetch, and later ticks produce nothing.
- R11: A control write with bit 0 set clears both start and repeat and halts playback, whatever bits 7 and 4 hold.
- R12: A control write with bit 7 clear halts playback. No fetch follows, even with ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| tick | input | 1 | Base-rate pulse, one cycle wide |
| fetch_stb | output | 1 | One-cycle strobe: new sample address valid |
| fetch_addr | output | 24 | Byte address of the sample to fetch |
| end_pulse | output | 1 | One-cycle pulse when the stop page is passed |
| active | output | 1 | Playback running (start bit) |
| out_left | output | 1 | Left output enable |
| out_right | output | 1 | Right output enable |
| volume | output | 8 | Volume byte, 0xFF loudest |

## Verification
A corrupted phase accumulator shows up as a wrong fetch count over a known number of ticks. The bench compares that count with floor(N*rate/65536) at the end of each rate run. A wrong address register or a wrong end comparison appears at `fetch_addr`, `end_pulse` and `active` in the very cycle after the faulty tick. Every cycle is checked against an arithmetic model, so such an error is caught one clock after it occurs. A fault in the looping or reset logic is exposed within one pass of a one-page sample, through a missing or extra end pulse, or through a fetch that arrives while the block should be halted.

// File: rtl/vrsp_pkg.sv
package vrsp_pkg;
  localparam int BYTE_W  = 8;
  localparam int PAGE_W  = 16;
  localparam int RATE_W  = 16;

  localparam logic [7:0] A_CTRL  = 8'h10;
  localparam logic [7:0] A_PAN   = 8'h11;
  localparam logic [7:0] A_BEG_L = 8'h12;
  localparam logic [7:0] A_BEG_H = 8'h13;
  localparam logic [7:0] A_END_L = 8'h14;
  localparam logic [7:0] A_END_H = 8'h15;
  localparam logic [7:0] A_RATE_L = 8'h19;
  localparam logic [7:0] A_RATE_H = 8'h1A;
  localparam logic [7:0] A_VOL   = 8'h1B;

  localparam int B_GO   = 7;
  localparam int B_LOOP = 4;
  localparam int B_CLR  = 0;
  localparam int B_LEFT = 7;
  localparam int B_RIGHT = 6;

  typedef struct packed {
    logic hit;   // control register written this cycle
    logic go;    // start requested (reset bit already folded in)
    logic loop;  // repeat requested (reset bit already folded in)
  } ctl_cmd_t;
endpackage

// File: rtl/vrsp_regs.sv
module vrsp_regs
  import vrsp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output ctl_cmd_t          cmd,
  output logic [PAGE_W-1:0] beg_page,
  output logic [PAGE_W-1:0] end_page,
  output logic [RATE_W-1:0] rate,
  output logic [BYTE_W-1:0] vol,
  output logic              pan_l,
  output logic              pan_r
);
  logic [PAGE_W-1:0] beg_q, beg_d, end_q, end_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic [BYTE_W-1:0] vol_q, vol_d;
  logic              pl_q, pl_d, pr_q, pr_d;

  always_comb begin
    beg_d  = beg_q;
    end_d  = end_q;
    rate_d = rate_q;
    vol_d  = vol_q;
    pl_d   = pl_q;
    pr_d   = pr_q;
    unique case (wr_addr)
      A_BEG_L:  beg_d[BYTE_W-1:0]         = wr_data;
      A_BEG_H:  beg_d[PAGE_W-1:BYTE_W]    = wr_data;
      A_END_L:  end_d[BYTE_W-1:0]         = wr_data;
      A_END_H:  end_d[PAGE_W-1:BYTE_W]    = wr_data;
      A_RATE_L: rate_d[BYTE_W-1:0]        = wr_data;
      A_RATE_H: rate_d[RATE_W-1:BYTE_W]   = wr_data;
      A_VOL:    vol_d                     = wr_data;
      A_PAN: begin
        pl_d = wr_data[B_LEFT];
        pr_d = wr_data[B_RIGHT];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beg_q  <= '0;
      end_q  <= '0;
      rate_q <= '0;
      vol_q  <= '0;
      pl_q   <= 1'b0;
      pr_q   <= 1'b0;
    end else if (wr_en) begin
      beg_q  <= beg_d;
      end_q  <= end_d;
      rate_q <= rate_d;
      vol_q  <= vol_d;
      pl_q   <= pl_d;
      pr_q   <= pr_d;
    end
  end

  always_comb begin
    cmd.hit  = wr_en && (wr_addr == A_CTRL);
    cmd.go   = wr_data[B_GO]   && !wr_data[B_CLR];
    cmd.loop = wr_data[B_LOOP] && !wr_data[B_CLR];
  end

  assign beg_page = beg_q;
  assign end_page = end_q;
  assign rate     = rate_q;
  assign vol      = vol_q;
  assign pan_l    = pl_q;
  assign pan_r    = pr_q;
endmodule

// File: rtl/vrsp_phase.sv
module vrsp_phase #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [ACC_W-1:0] step,
  output logic             carry
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic [ACC_W:0]   sum;

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, step};
    carry = adv && sum[ACC_W];
    acc_d = acc_q;
    if (clr)      acc_d = '0;
    else if (adv) acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc_q <= '0;
    else if (clr || adv) acc_q <= acc_d;
  end
endmodule

// File: rtl/vrsp_seq.sv
module vrsp_seq
  import vrsp_pkg::*;
#(
  parameter int PG_W  = 16,
  parameter int OFS_W = 8,
  localparam int ADDR_W = PG_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_cmd_t          cmd,
  input  logic              carry,
  input  logic [PG_W-1:0]   beg_page,
  input  logic [PG_W-1:0]   end_page,
  output logic              running,
  output logic              stb,
  output logic [ADDR_W-1:0] addr,
  output logic              endp
);
  logic [ADDR_W-1:0] addr_q, addr_d, base, last;
  logic              run_q, run_d, loop_q, loop_d, stb_q, stb_d, endp_q, endp_d;

  assign base = {beg_page, {OFS_W{1'b0}}};
  assign last = {end_page, {OFS_W{1'b1}}};

  always_comb begin
    run_d  = run_q;
    loop_d = loop_q;
    addr_d = addr_q;
    stb_d  = 1'b0;
    endp_d = 1'b0;
    if (cmd.hit) begin
      run_d  = cmd.go;
      loop_d = cmd.loop;
      if (cmd.go) begin
        addr_d = base;
        stb_d  = 1'b1;
      end
    end else if (carry) begin
      if (addr_q == last) begin
        endp_d = 1'b1;
        if (loop_q) begin
          addr_d = base;
          stb_d  = 1'b1;
        end else begin
          run_d = 1'b0;
        end
      end else begin
        addr_d = addr_q + 1'b1;
        stb_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      loop_q <= 1'b0;
      addr_q <= '0;
      stb_q  <= 1'b0;
      endp_q <= 1'b0;
    end else begin
      run_q  <= run_d;
      loop_q <= loop_d;
      addr_q <= addr_d;
      stb_q  <= stb_d;
      endp_q <= endp_d;
    end
  end

  assign running = run_q;
  assign stb     = stb_q;
  assign addr    = addr_q;
  assign endp    = endp_q;
endmodule

// File: rtl/vrsp_player.sv
module vrsp_player
  import vrsp_pkg::*;
#(
  parameter int OFS_W = 8,
  localparam int ADDR_W = PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              tick,
  output logic              fetch_stb,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              end_pulse,
  output logic              active,
  output logic              out_left,
  output logic              out_right,
  output logic [7:0]        volume
);
  ctl_cmd_t          cmd;
  logic [PAGE_W-1:0] beg_page, end_page;
  logic [RATE_W-1:0] rate;
  logic              carry, adv, clr;

  vrsp_regs regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cmd(cmd), .beg_page(beg_page), .end_page(end_page), .rate(rate),
    .vol(volume), .pan_l(out_left), .pan_r(out_right)
  );

  assign clr = cmd.hit && cmd.go;
  assign adv = tick && active && !cmd.hit;

  vrsp_phase #(.ACC_W(RATE_W)) phase_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv), .step(rate), .carry(carry)
  );

  vrsp_seq #(.PG_W(PAGE_W), .OFS_W(OFS_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .carry(carry),
    .beg_page(beg_page), .end_page(end_page),
    .running(active), .stb(fetch_stb), .addr(fetch_addr), .endp(end_pulse)
  );
endmodule

// File: rtl/vrsp_player_chk.sv
module vrsp_player_chk #(
  parameter int ADDR_W = 24,
  parameter int OFS_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              tick,
  input logic              fetch_stb,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              end_pulse,
  input logic              active
);
  logic [ADDR_W-1:0] prev_fetch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         prev_fetch <= '0;
    else if (fetch_stb) prev_fetch <= fetch_addr;
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> (!fetch_stb && !end_pulse));

  // R4
  fetch_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> active);

  // R5
  start_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb && !$past(active)) |-> (fetch_addr[OFS_W-1:0] == '0));

  // R9
  loop_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb && end_pulse) |-> (fetch_addr[OFS_W-1:0] == '0));

  // R6
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_stb && !end_pulse && !$past(wr_en)) |-> (fetch_addr == prev_fetch + 1'b1));

  // R8
  end_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> $past(tick));

  // R10
  end_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    end_pulse |-> (fetch_stb == active));
endmodule

bind vrsp_player vrsp_player_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .fetch_stb(fetch_stb),
  .fetch_addr(fetch_addr), .end_pulse(end_pulse), .active(active)
);

// File: tb/vrsp_player_tb_top.sv
`timescale 1ns/1ps
module vrsp_player_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        tick = 1'b0;
  logic        fetch_stb, end_pulse, active, out_left, out_right;
  logic [23:0] fetch_addr;
  logic [7:0]  volume;

  always #2.5 clk = ~clk;

  vrsp_player dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .fetch_stb(fetch_stb), .fetch_addr(fetch_addr), .end_pulse(end_pulse),
    .active(active), .out_left(out_left), .out_right(out_right), .volume(volume)
  );

  int checks = 0, fails = 0;
  int n_fetch, n_end, n_tick;
  logic [15:0] m_beg = '0, m_end = '0, m_rate = '0;
  logic [16:0] m_acc = '0;
  logic [23:0] m_addr = '0;
  logic        m_run = 1'b0, m_loop = 1'b0, e_stb = 1'b0, e_end = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk({tag, " stb"}, 32'(fetch_stb), 32'(e_stb));
    chk({tag, " end"}, 32'(end_pulse), 32'(e_end));
    chk({tag, " active"}, 32'(active), 32'(m_run));
    if (e_stb) chk({tag, " addr"}, 32'(fetch_addr), 32'(m_addr));
    if (fetch_stb) n_fetch++;
    if (end_pulse) n_end++;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; tick = 1'b0;
    e_stb = 1'b0; e_end = 1'b0;
    case (a)
      8'h12: m_beg[7:0]   = d;
      8'h13: m_beg[15:8]  = d;
      8'h14: m_end[7:0]   = d;
      8'h15: m_end[15:8]  = d;
      8'h19: m_rate[7:0]  = d;
      8'h1A: m_rate[15:8] = d;
      8'h10: begin
        if (d[0]) begin m_run = 1'b0; m_loop = 1'b0; end
        else begin
          m_run = d[7]; m_loop = d[4];
          if (d[7]) begin m_addr = {m_beg, 8'h00}; m_acc = '0; e_stb = 1'b1; end
        end
      end
      default: ;
    endcase
    @(posedge clk); #1;
    wr_en = 1'b0;
    compare(tag);
  endtask

  task automatic step(input logic t, input string tag);
    @(negedge clk);
    tick = t; e_stb = 1'b0; e_end = 1'b0;
    if (t && m_run) begin
      m_acc = {1'b0, m_acc[15:0]} + {1'b0, m_rate};
      if (m_acc[16]) begin
        if (m_addr == {m_end, 8'hFF}) begin
          e_end = 1'b1;
          if (m_loop) begin m_addr = {m_beg, 8'h00}; e_stb = 1'b1; end
          else m_run = 1'b0;
        end else begin
          m_addr = m_addr + 1'b1; e_stb = 1'b1;
        end
      end
    end
    if (t) n_tick++;
    @(posedge clk); #1;
    tick = 1'b0;
    compare(tag);
  endtask

  task automatic pages(input logic [15:0] b, input logic [15:0] e, input logic [15:0] r);
    wr(8'h12, b[7:0], "R5"); wr(8'h13, b[15:8], "R5");
    wr(8'h14, e[7:0], "R5"); wr(8'h15, e[15:8], "R5");
    wr(8'h19, r[7:0], "R6"); wr(8'h1A, r[15:8], "R6");
  endtask

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    logic [15:0] rates [5] = '{16'h0000, 16'h0100, 16'h1234, 16'h8000, 16'hFFFF};
    // R1 reset state
    #12;
    chk("R1 stb", 32'(fetch_stb), 0); chk("R1 end", 32'(end_pulse), 0);
    chk("R1 active", 32'(active), 0); chk("R1 pan", 32'({out_left, out_right}), 0);
    chk("R1 vol", 32'(volume), 0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, "R1"); step(1'b0, "R1");

    // R2 pan sweep
    for (int i = 0; i < 4; i++) begin
      wr(8'h11, {i[1:0], 6'h15}, "R2");
      chk("R2 left", 32'(out_left), 32'(i[1]));
      chk("R2 right", 32'(out_right), 32'(i[0]));
    end
    // R3 volume
    foreach (rates[k]) begin
      wr(8'h1B, rates[k][15:8] ^ 8'h5A, "R3");
      chk("R3 volume", 32'(volume), 32'(rates[k][15:8] ^ 8'h5A));
    end

    // R4 R5 R6 R7 rate sweep, ticks with gaps
    foreach (rates[k]) begin
      pages(16'h1234, 16'hFFF0, rates[k]);
      wr(8'h10, 8'h80, "R4 start");
      n_fetch = 0; n_tick = 0;
      for (int c = 0; c < 700; c++) step(c % 7 != 3, "R6 rate");
      chk("R6 fetch count", 32'(n_fetch), 32'((longint'(n_tick) * rates[k]) >> 16));
      for (int c = 0; c < 4; c++) step(1'b0, "R7 idle");
      // R12 halt by clearing start
      wr(8'h10, 8'h00, "R12 halt");
      for (int c = 0; c < 6; c++) step(1'b1, "R12 quiet");
    end

    // R8 R10 one-page sample without repeat
    pages(16'h0003, 16'h0003, 16'hFFFF);
    wr(8'h10, 8'h80, "R4");
    n_end = 0;
    for (int c = 0; c < 300; c++) step(1'b1, "R10 stop");
    chk("R8 end count", 32'(n_end), 1);
    chk("R10 halted", 32'(active), 0);

    // R9 repeat
    wr(8'h10, 8'h90, "R9");
    n_end = 0;
    for (int c = 0; c < 700; c++) step(1'b1, "R9 loop");
    chk("R9 end count", 32'(n_end), 2);
    chk("R9 still active", 32'(active), 1);

    // R11 reset bit dominates start and repeat
    wr(8'h10, 8'h91, "R11 clear");
    for (int c = 0; c < 6; c++) step(1'b1, "R11 quiet");
    wr(8'h10, 8'h80, "R11 restart");
    n_end = 0;
    for (int c = 0; c < 300; c++) step(1'b1, "R11 no repeat");
    chk("R11 repeat cleared", 32'(n_end), 1);

    // R5 R9 top of address space, half rate
    pages(16'hFFFF, 16'hFFFF, 16'h8000);
    wr(8'h10, 8'h90, "R5 top");
    n_end = 0;
    for (int c = 0; c < 1100; c++) step(c % 3 != 0, "R5 top");
    chk("R9 top ends", 32'(n_end), 1);
    finish_up();
  end
endmodule